// File: doc/BRIEF.md
# Flash Readout Protection Access Controller

This block sits between the bus masters of a microcontroller and its flash, SRAM and peripheral space and enforces a three-level readout protection policy. The active level comes from a protection byte held in flash and delivered once after power-on. Until that byte arrives, the controller assumes the strictest level. Every access from the debug access port, the DMA master and the CPU data port passes through a per-master gate. The gate either forwards the access to the memory side as a grant, or refuses it. A refused access returns all-zero data with an error flag, one cycle after the request.

At the middle level the flash becomes locked as soon as a debugger requests debug power. The lock stays set after the debugger withdraws that request. Only a power-on reset clears it, and it comes back at once if the debugger is still powered when the level reloads. While the lock is set, flash traffic from the debug port and from the DMA master is refused, but the CPU keeps full access. At the top level the debug port is refused for every address, including SRAM, and entry into the built-in bootloader is blocked.

A small request interface asks for a new level. A raise goes straight to an option-byte write. A lowering from the middle level to level 0 first holds an erase request until the erase completes, and only then writes the option byte. Any request made at the top level is rejected. A request for an undefined level is also rejected.

Top module: `rdp_guard`

## Requirements
- R1: The protection byte is decoded when `optValid` is high: 0xA5 selects level 0, 0xCC selects level 2, and every other value selects level 1. `curLevel` reports the level in the following cycle as 0, 1 or 2, and `levelValid` rises in that same cycle.
- R2: While `porN` is low, and after it until the first protection byte loads, `curLevel` reads 2 and `levelValid` reads 0. In this state every debug-port request is refused.
- R3: At level 0 all three masters get flash and SRAM access. The response carries the memory data for reads.
- R4: At level 1 with `dbgPwrUpReq` high, debug flash accesses are refused: `rspErr` is 1 and `rspData` is 0 one cycle after the request. Debug SRAM accesses are still granted.
- R5: Once engaged, the flash lock survives the fall of `dbgPwrUpReq`. Only a power-on reset followed by a load with `dbgPwrUpReq` low leaves flash unlocked.
- R6: While the lock is set, DMA flash accesses are refused in the same way as debug ones. CPU flash accesses are always granted.
- R7: At level 2 every debug-port request is refused whatever its address. `bootLdrEn` stays 0.
- R8: A level-change request is rejected with a one-cycle `cfgRej` pulse, and raises neither `eraseReq` nor `optWrReq`, in three cases: the level is 2, the level is not yet loaded, or the requested level code is 3.
- R9: Lowering from level 1 to level 0 holds `eraseReq` until `eraseAck` arrives. Only after that does it raise `optWrReq` with byte 0xA5. `cfgAck` pulses the cycle after `optWrAck`.
- R10: A raise raises no erase request and writes the target byte at once (0xFF for level 1, 0xCC for level 2). A request for the current level is acknowledged with no write.
- R11: At levels 0 and 1, `bootLdrEn` follows `bootLdrReq`.
- R12: At level 0, `dbgPwrUpReq` never locks flash.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| porN | input | 1 | Power-on reset, active low, asynchronous |
| optValid | input | 1 | Protection byte delivered this cycle |
| optByte | input | 8 | Protection byte read from flash |
| dbgPwrUpReq | input | 1 | Debug power-up request from the debug port |
| bootLdrReq | input | 1 | Request to start from the built-in bootloader |
| bootLdrEn | output | 1 | Bootloader start permitted |
| curLevel | output | 2 | Active protection level (2 until loaded) |
| levelValid | output | 1 | Protection byte has been loaded |
| mReq | input | 3 | Access request per master (0 debug, 1 DMA, 2 CPU) |
| mWe | input | 3 | Write flag per master |
| mAddr | input | 3x32 | Address per master |
| memRdata | input | 3x32 | Read data from memory per master |
| memGnt | output | 3 | Access forwarded to memory |
| rspValid | output | 3 | Response valid, one cycle after request |
| rspErr | output | 3 | Access was refused |
| rspData | output | 3x32 | Read data, zero when refused or on writes |
| cfgWrEn | input | 1 | Level-change request strobe |
| cfgLevel | input | 2 | Requested level |
| cfgAck | output | 1 | Level change finished |
| cfgRej | output | 1 | Level change rejected |
| eraseReq | output | 1 | Mass-erase request |
| eraseAck | input | 1 | Mass erase complete |
| optWrReq | output | 1 | Protection byte write request |
| optWrByte | output | 8 | Protection byte to write |
| optWrAck | input | 1 | Protection byte write complete |

## Verification
The hardest state to reach is a level-1 device whose debugger has already gone away but whose flash must stay locked. No port shows the lock directly. The stimulus powers the debugger up and then drops the request, and from that point it watches only for refusals on the debug and DMA ports. It then applies a clean power-on reset with the debugger off, which proves the lock clears only through that path. The erase-then-write ordering is driven by holding the erase acknowledge back for several cycles, to show that no write starts early.

// File: rtl/rdp_pkg.sv
package rdp_pkg;
  typedef enum logic [1:0] {
    LVL0 = 2'd0,
    LVL1 = 2'd1,
    LVL2 = 2'd2
  } rdpLevel_t;

  // Master slots of the access ports
  localparam int NUM_MASTERS = 3;
  localparam int MST_DBG = 0;
  localparam int MST_DMA = 1;
  localparam int MST_CPU = 2;

  // Strobes from control to the access datapath
  typedef struct packed {
    logic dbgOff;
    logic flashLock;
  } gateCtl_t;

  typedef enum logic [1:0] {
    CS_IDLE,
    CS_ERASE,
    CS_PROG
  } cfgState_t;
endpackage

// File: rtl/rdp_ctrl.sv
module rdp_ctrl
  import rdp_pkg::*;
#(
  parameter logic [7:0] OPT_L0 = 8'hA5,
  parameter logic [7:0] OPT_L1 = 8'hFF,
  parameter logic [7:0] OPT_L2 = 8'hCC
) (
  input  logic       clk,
  input  logic       porN,
  input  logic       optValid,
  input  logic [7:0] optByte,
  input  logic       dbgPwrUpReq,
  input  logic       bootLdrReq,
  input  logic       cfgWrEn,
  input  logic [1:0] cfgLevel,
  input  logic       eraseAck,
  input  logic       optWrAck,
  output gateCtl_t   gate,
  output logic [1:0] curLevel,
  output logic       levelValid,
  output logic       bootLdrEn,
  output logic       cfgAck,
  output logic       cfgRej,
  output logic       eraseReq,
  output logic       optWrReq,
  output logic [7:0] optWrByte
);
  rdpLevel_t levelQ;
  rdpLevel_t levelEff;
  logic      loadedQ;
  logic      lockQ;
  logic      lockSet;
  cfgState_t stateQ;
  logic [7:0] targetQ;
  logic      ackQ;
  logic      rejQ;

  function automatic rdpLevel_t decodeOpt(input logic [7:0] b);
    if (b == OPT_L0)      return LVL0;
    else if (b == OPT_L2) return LVL2;
    else                  return LVL1;
  endfunction

  function automatic logic [7:0] encodeLvl(input logic [1:0] l);
    case (l)
      2'd0:    return OPT_L0;
      2'd1:    return OPT_L1;
      default: return OPT_L2;
    endcase
  endfunction

  // Level register: loaded once per delivery of the option byte
  always_ff @(posedge clk or negedge porN) begin
    if (!porN) begin
      levelQ  <= LVL2;
      loadedQ <= 1'b0;
    end else if (optValid) begin
      levelQ  <= decodeOpt(optByte);
      loadedQ <= 1'b1;
    end
  end

  assign levelEff = loadedQ ? levelQ : LVL2;

  // Sticky lock: set by a debugger power-up, cleared only by power-on reset
  assign lockSet = dbgPwrUpReq && loadedQ && (levelQ != LVL0);

  always_ff @(posedge clk or negedge porN) begin
    if (!porN) lockQ <= 1'b0;
    else if (lockSet) lockQ <= 1'b1;
  end

  always_comb begin
    gate.dbgOff    = (levelEff == LVL2);
    gate.flashLock = (lockQ || lockSet) && loadedQ && (levelQ != LVL0);
  end

  assign curLevel   = levelEff;
  assign levelValid = loadedQ;
  assign bootLdrEn  = bootLdrReq && (levelEff != LVL2);

  // Level-change sequencer
  always_ff @(posedge clk or negedge porN) begin
    if (!porN) begin
      stateQ  <= CS_IDLE;
      targetQ <= 8'h00;
      ackQ    <= 1'b0;
      rejQ    <= 1'b0;
    end else begin
      ackQ <= 1'b0;
      rejQ <= 1'b0;
      case (stateQ)
        CS_IDLE: begin
          if (cfgWrEn) begin
            if (!loadedQ || levelQ == LVL2 || cfgLevel == 2'd3) begin
              rejQ <= 1'b1;
            end else if (cfgLevel == levelQ) begin
              ackQ <= 1'b1;
            end else if (cfgLevel < levelQ) begin
              targetQ <= encodeLvl(cfgLevel);
              stateQ  <= CS_ERASE;
            end else begin
              targetQ <= encodeLvl(cfgLevel);
              stateQ  <= CS_PROG;
            end
          end
        end
        CS_ERASE: begin
          if (cfgWrEn) rejQ <= 1'b1;
          if (eraseAck) stateQ <= CS_PROG;
        end
        CS_PROG: begin
          if (cfgWrEn) rejQ <= 1'b1;
          if (optWrAck) begin
            stateQ <= CS_IDLE;
            ackQ   <= 1'b1;
          end
        end
        default: stateQ <= CS_IDLE;
      endcase
    end
  end

  assign eraseReq  = (stateQ == CS_ERASE);
  assign optWrReq  = (stateQ == CS_PROG);
  assign optWrByte = targetQ;
  assign cfgAck    = ackQ;
  assign cfgRej    = rejQ;
endmodule

// File: rtl/rdp_access.sv
module rdp_access
  import rdp_pkg::*;
#(
  parameter int          AW          = 32,
  parameter int          DW          = 32,
  parameter logic [31:0] FLASH_BASE  = 32'h0800_0000,
  parameter int          FLASH_LOG2  = 20,
  parameter logic [31:0] SRAM_BASE   = 32'h2000_0000,
  parameter int          SRAM_LOG2   = 16
) (
  input  logic                             clk,
  input  logic                             porN,
  input  gateCtl_t                         gate,
  input  logic [NUM_MASTERS-1:0]           mReq,
  input  logic [NUM_MASTERS-1:0]           mWe,
  input  logic [NUM_MASTERS-1:0][AW-1:0]   mAddr,
  input  logic [NUM_MASTERS-1:0][DW-1:0]   memRdata,
  output logic [NUM_MASTERS-1:0]           memGnt,
  output logic [NUM_MASTERS-1:0]           rspValid,
  output logic [NUM_MASTERS-1:0]           rspErr,
  output logic [NUM_MASTERS-1:0][DW-1:0]   rspData
);
  localparam logic [AW-1:0] FLASH_MASK = ~((AW'(1) << FLASH_LOG2) - AW'(1));
  localparam logic [AW-1:0] SRAM_MASK  = ~((AW'(1) << SRAM_LOG2) - AW'(1));
  localparam logic [AW-1:0] FLASH_B    = FLASH_BASE[AW-1:0];
  localparam logic [AW-1:0] SRAM_B     = SRAM_BASE[AW-1:0];

  for (genvar i = 0; i < NUM_MASTERS; i++) begin : g_port
    logic isFlash;
    logic isSram;
    logic allow;

    assign isFlash = ((mAddr[i] ^ FLASH_B) & FLASH_MASK) == '0;
    assign isSram  = ((mAddr[i] ^ SRAM_B) & SRAM_MASK) == '0;

    if (i == MST_DBG) begin : g_dbg
      // Debug port: fully off at top level, flash off while locked
      assign allow = !gate.dbgOff && !(isFlash && gate.flashLock);
    end else if (i == MST_DMA) begin : g_dma
      assign allow = !(isFlash && gate.flashLock);
    end else begin : g_cpu
      assign allow = 1'b1;
    end

    assign memGnt[i] = mReq[i] && allow;

    always_ff @(posedge clk or negedge porN) begin
      if (!porN) begin
        rspValid[i] <= 1'b0;
        rspErr[i]   <= 1'b0;
        rspData[i]  <= '0;
      end else begin
        rspValid[i] <= mReq[i];
        rspErr[i]   <= mReq[i] && !allow;
        rspData[i]  <= (mReq[i] && allow && !mWe[i]) ? memRdata[i] : '0;
      end
    end

    logic unusedSram;
    assign unusedSram = isSram;
  end
endmodule

// File: rtl/rdp_guard.sv
module rdp_guard
  import rdp_pkg::*;
#(
  parameter int          AW         = 32,
  parameter int          DW         = 32,
  parameter logic [31:0] FLASH_BASE = 32'h0800_0000,
  parameter int          FLASH_LOG2 = 20,
  parameter logic [31:0] SRAM_BASE  = 32'h2000_0000,
  parameter int          SRAM_LOG2  = 16,
  parameter logic [7:0]  OPT_L0     = 8'hA5,
  parameter logic [7:0]  OPT_L1     = 8'hFF,
  parameter logic [7:0]  OPT_L2     = 8'hCC
) (
  input  logic                 clk,
  input  logic                 porN,
  input  logic                 optValid,
  input  logic [7:0]           optByte,
  input  logic                 dbgPwrUpReq,
  input  logic                 bootLdrReq,
  output logic                 bootLdrEn,
  output logic [1:0]           curLevel,
  output logic                 levelValid,
  input  logic [2:0]           mReq,
  input  logic [2:0]           mWe,
  input  logic [2:0][AW-1:0]   mAddr,
  input  logic [2:0][DW-1:0]   memRdata,
  output logic [2:0]           memGnt,
  output logic [2:0]           rspValid,
  output logic [2:0]           rspErr,
  output logic [2:0][DW-1:0]   rspData,
  input  logic                 cfgWrEn,
  input  logic [1:0]           cfgLevel,
  output logic                 cfgAck,
  output logic                 cfgRej,
  output logic                 eraseReq,
  input  logic                 eraseAck,
  output logic                 optWrReq,
  output logic [7:0]           optWrByte,
  input  logic                 optWrAck
);
  gateCtl_t gate;
  logic     lockActive;

  rdp_ctrl #(
    .OPT_L0(OPT_L0), .OPT_L1(OPT_L1), .OPT_L2(OPT_L2)
  ) u_ctrl (
    .clk(clk), .porN(porN), .optValid(optValid), .optByte(optByte),
    .dbgPwrUpReq(dbgPwrUpReq), .bootLdrReq(bootLdrReq),
    .cfgWrEn(cfgWrEn), .cfgLevel(cfgLevel), .eraseAck(eraseAck),
    .optWrAck(optWrAck), .gate(gate), .curLevel(curLevel),
    .levelValid(levelValid), .bootLdrEn(bootLdrEn), .cfgAck(cfgAck),
    .cfgRej(cfgRej), .eraseReq(eraseReq), .optWrReq(optWrReq),
    .optWrByte(optWrByte)
  );

  rdp_access #(
    .AW(AW), .DW(DW), .FLASH_BASE(FLASH_BASE), .FLASH_LOG2(FLASH_LOG2),
    .SRAM_BASE(SRAM_BASE), .SRAM_LOG2(SRAM_LOG2)
  ) u_access (
    .clk(clk), .porN(porN), .gate(gate), .mReq(mReq), .mWe(mWe),
    .mAddr(mAddr), .memRdata(memRdata), .memGnt(memGnt),
    .rspValid(rspValid), .rspErr(rspErr), .rspData(rspData)
  );

  assign lockActive = gate.flashLock;
endmodule

// File: rtl/rdp_guard_chk.sv
module rdp_guard_chk #(
  parameter int         DW     = 32,
  parameter logic [7:0] OPT_L0 = 8'hA5
) (
  input logic                clk,
  input logic                porN,
  input logic [1:0]          curLevel,
  input logic                levelValid,
  input logic [2:0]          mReq,
  input logic [2:0]          memGnt,
  input logic [2:0]          rspErr,
  input logic [2:0][DW-1:0]  rspData,
  input logic                cfgWrEn,
  input logic                cfgRej,
  input logic                eraseReq,
  input logic                eraseAck,
  input logic                optWrReq,
  input logic [7:0]          optWrByte,
  input logic                flashLock
);
  assert_preload_dbg_off_R2: assert property (@(posedge clk) disable iff (!porN)
    (!levelValid && mReq[0]) |-> !memGnt[0]);

  assert_top_dbg_off_R7: assert property (@(posedge clk) disable iff (!porN)
    (curLevel == 2'd2 && mReq[0]) |-> !memGnt[0]);

  assert_refused_zero_R4: assert property (@(posedge clk) disable iff (!porN)
    rspErr[0] |-> (rspData[0] == '0));

  assert_dma_refused_zero_R6: assert property (@(posedge clk) disable iff (!porN)
    rspErr[1] |-> (rspData[1] == '0));

  assert_lock_sticky_R5: assert property (@(posedge clk) disable iff (!porN)
    ($past(flashLock) && curLevel == 2'd1 && $past(curLevel) == 2'd1) |-> flashLock);

  assert_top_no_change_R8: assert property (@(posedge clk) disable iff (!porN)
    (cfgWrEn && curLevel == 2'd2 && !eraseReq && !optWrReq) |=> (cfgRej && !eraseReq && !optWrReq));

  assert_erase_first_R9: assert property (@(posedge clk) disable iff (!porN)
    ($rose(optWrReq) && optWrByte == OPT_L0) |-> $past(eraseReq && eraseAck));

  assert_cpu_never_refused_R6: assert property (@(posedge clk) disable iff (!porN)
    mReq[2] |-> memGnt[2]);
endmodule

bind rdp_guard rdp_guard_chk #(.DW(DW), .OPT_L0(OPT_L0)) u_chk (
  .clk(clk), .porN(porN), .curLevel(curLevel), .levelValid(levelValid),
  .mReq(mReq), .memGnt(memGnt), .rspErr(rspErr), .rspData(rspData),
  .cfgWrEn(cfgWrEn), .cfgRej(cfgRej), .eraseReq(eraseReq),
  .eraseAck(eraseAck), .optWrReq(optWrReq), .optWrByte(optWrByte),
  .flashLock(lockActive)
);

// File: tb/rdp_guard_tb.sv
module rdp_guard_tb;
  localparam logic [31:0] MAGIC = 32'h5A5A_0F0F;
  localparam logic [31:0] FL    = 32'h0800_0100;
  localparam logic [31:0] SR    = 32'h2000_0040;

  logic              clk = 1'b0;
  logic              porN = 1'b0;
  logic              optValid = 1'b0;
  logic [7:0]        optByte = 8'h00;
  logic              dbgPwrUpReq = 1'b0;
  logic              bootLdrReq = 1'b0;
  logic              bootLdrEn;
  logic [1:0]        curLevel;
  logic              levelValid;
  logic [2:0]        mReq = '0;
  logic [2:0]        mWe = '0;
  logic [2:0][31:0]  mAddr = '0;
  logic [2:0][31:0]  memRdata;
  logic [2:0]        memGnt, rspValid, rspErr;
  logic [2:0][31:0]  rspData;
  logic              cfgWrEn = 1'b0;
  logic [1:0]        cfgLevel = 2'd0;
  logic              cfgAck, cfgRej, eraseReq, optWrReq;
  logic              eraseAck = 1'b0;
  logic              optWrAck = 1'b0;
  logic [7:0]        optWrByte;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  assign memRdata[0] = mAddr[0] ^ MAGIC;
  assign memRdata[1] = mAddr[1] ^ MAGIC;
  assign memRdata[2] = mAddr[2] ^ MAGIC;

  rdp_guard u_dut (
    .clk(clk), .porN(porN), .optValid(optValid), .optByte(optByte),
    .dbgPwrUpReq(dbgPwrUpReq), .bootLdrReq(bootLdrReq), .bootLdrEn(bootLdrEn),
    .curLevel(curLevel), .levelValid(levelValid), .mReq(mReq), .mWe(mWe),
    .mAddr(mAddr), .memRdata(memRdata), .memGnt(memGnt), .rspValid(rspValid),
    .rspErr(rspErr), .rspData(rspData), .cfgWrEn(cfgWrEn), .cfgLevel(cfgLevel),
    .cfgAck(cfgAck), .cfgRej(cfgRej), .eraseReq(eraseReq), .eraseAck(eraseAck),
    .optWrReq(optWrReq), .optWrByte(optWrByte), .optWrAck(optWrAck)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic powerOn();
    porN = 1'b0;
    tick(); tick();
    porN = 1'b1;
    tick();
  endtask

  task automatic loadOpt(input logic [7:0] b);
    optByte = b; optValid = 1'b1;
    tick();
    optValid = 1'b0;
  endtask

  task automatic access(input int m, input logic [31:0] a, input logic we,
                        input logic expOk, input string tag);
    mReq[m] = 1'b1; mWe[m] = we; mAddr[m] = a;
    #1;
    check({tag, " gnt"}, 32'(memGnt[m]), 32'(expOk));
    tick();
    mReq[m] = 1'b0; mWe[m] = 1'b0;
    check({tag, " valid"}, 32'(rspValid[m]), 32'd1);
    check({tag, " err"}, 32'(rspErr[m]), 32'(!expOk));
    check({tag, " data"}, rspData[m], (expOk && !we) ? (a ^ MAGIC) : 32'd0);
  endtask

  // R2: reset and pre-load state
  task automatic testPreload();
    porN = 1'b0; bootLdrReq = 1'b1;
    tick();
    mReq[0] = 1'b1; mAddr[0] = SR;
    #1;
    check("R2 level in reset", 32'(curLevel), 32'd2);
    check("R2 valid in reset", 32'(levelValid), 32'd0);
    check("R2 dbg gnt in reset", 32'(memGnt[0]), 32'd0);
    check("R2 boot in reset", 32'(bootLdrEn), 32'd0);
    check("R2 rsp in reset", 32'(rspValid), 32'd0);
    mReq[0] = 1'b0; bootLdrReq = 1'b0;
    porN = 1'b1;
    tick();
    access(0, SR, 1'b0, 1'b0, "R2 dbg unloaded");
  endtask

  // R1: option byte decode
  task automatic testDecode();
    loadOpt(8'hA5);
    check("R1 0xA5", 32'(curLevel), 32'd0);
    check("R1 valid", 32'(levelValid), 32'd1);
    powerOn(); loadOpt(8'hCC);
    check("R1 0xCC", 32'(curLevel), 32'd2);
    powerOn(); loadOpt(8'h3C);
    check("R1 0x3C", 32'(curLevel), 32'd1);
    powerOn(); loadOpt(8'hA4);
    check("R1 0xA4", 32'(curLevel), 32'd1);
  endtask

  // R3, R12, R11 at level 0
  task automatic testLevel0();
    powerOn(); loadOpt(8'hA5);
    access(0, FL, 1'b0, 1'b1, "R3 dbg flash");
    access(1, FL, 1'b0, 1'b1, "R3 dma flash");
    access(2, SR, 1'b0, 1'b1, "R3 cpu sram");
    access(0, SR, 1'b1, 1'b1, "R3 dbg sram write");
    dbgPwrUpReq = 1'b1;
    tick();
    access(0, FL, 1'b0, 1'b1, "R12 dbg flash powered");
    access(1, FL, 1'b0, 1'b1, "R12 dma flash powered");
    dbgPwrUpReq = 1'b0;
    bootLdrReq = 1'b1;
    #1;
    check("R11 boot at L0", 32'(bootLdrEn), 32'd1);
    bootLdrReq = 1'b0;
  endtask

  // R4, R5, R6 at level 1
  task automatic testLevel1Lock();
    powerOn(); loadOpt(8'h00);
    access(1, FL, 1'b0, 1'b1, "R5 dma flash before debugger");
    dbgPwrUpReq = 1'b1;
    tick();
    access(0, FL, 1'b0, 1'b0, "R4 dbg flash locked");
    access(0, SR, 1'b0, 1'b1, "R4 dbg sram read");
    access(0, SR, 1'b1, 1'b1, "R4 dbg sram write");
    access(1, FL, 1'b0, 1'b0, "R6 dma flash locked");
    access(1, SR, 1'b0, 1'b1, "R6 dma sram");
    access(2, FL, 1'b0, 1'b1, "R6 cpu flash");
    dbgPwrUpReq = 1'b0;
    tick(); tick();
    access(0, FL, 1'b0, 1'b0, "R5 dbg flash after power down");
    access(1, FL, 1'b0, 1'b0, "R5 dma flash after power down");
    powerOn(); loadOpt(8'h00);
    access(1, FL, 1'b0, 1'b1, "R5 dma flash after clean por");
    bootLdrReq = 1'b1;
    #1;
    check("R11 boot at L1", 32'(bootLdrEn), 32'd1);
    bootLdrReq = 1'b0;
  endtask

  // R7, R8 at level 2
  task automatic testLevel2();
    powerOn(); loadOpt(8'hCC);
    access(0, SR, 1'b0, 1'b0, "R7 dbg sram");
    access(0, FL, 1'b0, 1'b0, "R7 dbg flash");
    access(0, 32'h4000_0000, 1'b0, 1'b0, "R7 dbg periph");
    bootLdrReq = 1'b1;
    #1;
    check("R7 boot blocked", 32'(bootLdrEn), 32'd0);
    bootLdrReq = 1'b0;
    cfgWrEn = 1'b1; cfgLevel = 2'd0;
    tick();
    cfgWrEn = 1'b0;
    check("R8 reject at L2", 32'(cfgRej), 32'd1);
    check("R8 no erase", 32'(eraseReq), 32'd0);
    check("R8 no write", 32'(optWrReq), 32'd0);
    tick();
    check("R8 rej pulse", 32'(cfgRej), 32'd0);
    check("R8 still no erase", 32'(eraseReq), 32'd0);
  endtask

  // R9 lower 1 -> 0, R8 invalid code
  task automatic testLower();
    powerOn(); loadOpt(8'h3C);
    cfgWrEn = 1'b1; cfgLevel = 2'd3;
    tick();
    cfgWrEn = 1'b0;
    check("R8 reject code 3", 32'(cfgRej), 32'd1);
    check("R8 code 3 no write", 32'(optWrReq), 32'd0);
    cfgWrEn = 1'b1; cfgLevel = 2'd0;
    tick();
    cfgWrEn = 1'b0;
    check("R9 erase raised", 32'(eraseReq), 32'd1);
    check("R9 no early write", 32'(optWrReq), 32'd0);
    for (int k = 0; k < 4; k++) begin
      tick();
      check("R9 erase held", 32'(eraseReq), 32'd1);
      check("R9 write waits", 32'(optWrReq), 32'd0);
    end
    eraseAck = 1'b1;
    tick();
    eraseAck = 1'b0;
    check("R9 erase dropped", 32'(eraseReq), 32'd0);
    check("R9 write raised", 32'(optWrReq), 32'd1);
    check("R9 write byte", 32'(optWrByte), 32'hA5);
    check("R9 no ack yet", 32'(cfgAck), 32'd0);
    optWrAck = 1'b1;
    tick();
    optWrAck = 1'b0;
    check("R9 ack", 32'(cfgAck), 32'd1);
    check("R9 write done", 32'(optWrReq), 32'd0);
  endtask

  // R10 raise and same-level
  task automatic testRaise();
    powerOn(); loadOpt(8'hA5);
    cfgWrEn = 1'b1; cfgLevel = 2'd0;
    tick();
    cfgWrEn = 1'b0;
    check("R10 same level ack", 32'(cfgAck), 32'd1);
    check("R10 same level no write", 32'(optWrReq), 32'd0);
    cfgWrEn = 1'b1; cfgLevel = 2'd1;
    tick();
    cfgWrEn = 1'b0;
    check("R10 raise no erase", 32'(eraseReq), 32'd0);
    check("R10 raise write", 32'(optWrReq), 32'd1);
    check("R10 byte L1", 32'(optWrByte), 32'hFF);
    optWrAck = 1'b1;
    tick();
    optWrAck = 1'b0;
    check("R10 raise ack", 32'(cfgAck), 32'd1);
    cfgWrEn = 1'b1; cfgLevel = 2'd2;
    tick();
    cfgWrEn = 1'b0;
    check("R10 byte L2", 32'(optWrByte), 32'hCC);
    check("R10 L2 no erase", 32'(eraseReq), 32'd0);
    optWrAck = 1'b1;
    tick();
    optWrAck = 1'b0;
    check("R10 L2 ack", 32'(cfgAck), 32'd1);
  endtask

  initial begin
    #(4 * 200000);
    if (!finished) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    testPreload();
    testDecode();
    testLevel0();
    testLevel1Lock();
    testLevel2();
    testLower();
    testRaise();
    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end
endmodule